// File: doc/BRIEF.md
# Two-Dimensional Sparse Hit Scanner

This block keeps the binary hit map of one pixel readout chip and reads out only the pixels that were hit. The map is arranged as lines and columns. Each pixel has a latch that captures a hit while the gate input is high. The latch holds the hit until the hit is reported or a fast clear wipes the whole array.

A scan start request begins the readout. The scanner first picks the lowest-numbered line that holds any hit. It then walks the hit columns of that line from low to high, one per clock, and emits each hit as an address made of the line number joined with the column number. When the chosen line has no hits left, the scanner picks the next line that still holds hits. Empty lines and empty pixels cost no clock cycles.

Each reported pixel's latch is cleared when its address is emitted, so no hit is reported twice. A done flag rises once no hit line remains, and it rises right away when the array is empty. The array width is set by a parameter: 24 columns for the full array, or 16 columns for the small one, both with 24 lines.

Top module: `pixel_sparse_scan`

## Requirements
- R1: After reset `addr_valid_o` and `done_o` are 0 and every pixel latch is empty, so a first scan reports no address.
- R2: A pixel latch sets on a rising clock edge only if `gate_i` is high and its `hit_i` bit is 1. While `gate_i` is low, `hit_i` has no effect. A set latch stays set through later gated captures until it is reported or cleared.
- R3: `fast_clr_i` high at a clock edge empties every pixel latch, and it wins over a capture in the same cycle.
- R4: Pixel (line l, column c) is bit `l*NUM_COLS + c` of `hit_i`. Its address is `addr_o = {l[4:0], c[4:0]}`, with lines and columns counted from 0.
- R5: Addresses come out line by line in ascending line order. Lines with no hits are skipped.
- R6: Within a line, the hit columns come out in ascending order on consecutive cycles, one pulse of `addr_valid_o` per address. Every latched hit is reported exactly once per scan.
- R7: A reported pixel's latch is cleared, so a second scan with no new capture reports nothing.
- R8: Count the clock edge that samples `scan_start_i` as edge 1. The first address is valid after edge 3. `done_o` rises after edge `2 + sum over hit lines of (hits_in_line + 2)`.
- R9: `done_o` stays high from the end of a scan until the next accepted `scan_start_i`, which drops it at the sampling edge. It is never high together with `addr_valid_o`. With an empty array it rises after edge 2.
- R10: With `NUM_COLS = 16` the same ordering, address format and timing hold over a 16 by 24 array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| gate_i | input | 1 | Hit capture enable |
| fast_clr_i | input | 1 | Clears all pixel latches |
| hit_i | input | NUM_LINES*NUM_COLS | Discriminated hits, bit l*NUM_COLS+c for pixel (l,c) |
| scan_start_i | input | 1 | Begins a readout scan when the scanner is idle |
| addr_valid_o | output | 1 | One-cycle strobe qualifying addr_o |
| addr_o | output | LINE_W+COL_W | Hit address {line, column} |
| done_o | output | 1 | No hit lines remain; held until the next scan start |

## Verification
Every single pixel position is tried alone, across both array widths. These runs separate errors in the line/column index arithmetic and in the address packing at each boundary, including the last column of a line and the last line. Pseudo-random maps of several densities, a map with only even lines, and a full map check the line skipping, the column ordering and the exact cycle count of each scan. A scan with nothing changed in between must come back empty. Captures with the gate low, a fast clear, and a fast clear coinciding with a gated capture must each leave the array empty. Separately, two gated captures without a scan in between must merge their hits.

// File: rtl/pss_pkg.sv
package pss_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEEK = 2'd1,
      ST_WALK = 2'd2
   } scan_state_t;
endpackage

// File: rtl/first_set_finder.sv
module first_set_finder #(
   parameter int W     = 24,
   parameter int IDX_W = 5
) (
   input  logic [W-1:0]     vec_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   initial begin
      assert (W <= (1 << IDX_W)) else $error("index width too small for vector");
   end

   always_comb begin
      any_o = |vec_i;
      idx_o = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec_i[i]) idx_o = IDX_W'(i);
      end
   end
endmodule

// File: rtl/hit_latch_array.sv
module hit_latch_array #(
   parameter int NPIX = 576
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            gate_i,
   input  logic            fast_clr_i,
   input  logic [NPIX-1:0] hit_i,
   input  logic [NPIX-1:0] clr_mask_i,
   output logic [NPIX-1:0] latch_q
);
   logic [NPIX-1:0] capture;

   assign capture = gate_i ? hit_i : '0;

   always_ff @(posedge clk) begin
      if (!rst_n || fast_clr_i) latch_q <= '0;
      else                      latch_q <= (latch_q & ~clr_mask_i) | capture;
   end

   AST_FAST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      fast_clr_i |=> (latch_q == '0)); // R3

   AST_NO_CAPTURE_UNGATED: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_i |=> ((latch_q & ~$past(latch_q)) == '0)); // R2

   AST_CLEAR_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr_mask_i)); // R7

   AST_REPORTED_GONE: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask_i != '0) && !gate_i |=> ((latch_q & $past(clr_mask_i)) == '0)); // R7
endmodule

// File: rtl/pixel_sparse_scan.sv
module pixel_sparse_scan #(
   parameter int NUM_COLS  = 24,
   parameter int NUM_LINES = 24,
   parameter int COL_W     = 5,
   parameter int LINE_W    = 5
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            gate_i,
   input  logic                            fast_clr_i,
   input  logic [NUM_LINES*NUM_COLS-1:0]   hit_i,
   input  logic                            scan_start_i,
   output logic                            addr_valid_o,
   output logic [LINE_W+COL_W-1:0]         addr_o,
   output logic                            done_o
);
   import pss_pkg::*;

   localparam int NPIX   = NUM_LINES * NUM_COLS;
   localparam int ADDR_W = LINE_W + COL_W;

   initial begin
      assert (NUM_COLS  >= 1 && NUM_COLS  <= (1 << COL_W))  else $error("NUM_COLS out of range");
      assert (NUM_LINES >= 1 && NUM_LINES <= (1 << LINE_W)) else $error("NUM_LINES out of range");
   end

   scan_state_t         state;
   logic [LINE_W-1:0]   cur_line;
   logic [NPIX-1:0]     latch_q;
   logic [NPIX-1:0]     clr_mask;
   logic [NUM_LINES-1:0] line_any;
   logic [NUM_COLS-1:0] rows [NUM_LINES];
   logic [NUM_COLS-1:0] row_bits;
   logic                any_line, any_col, walk_hit;
   logic [LINE_W-1:0]   first_line;
   logic [COL_W-1:0]    first_col;

   hit_latch_array #(.NPIX(NPIX)) u_latches (
      .clk        (clk),
      .rst_n      (rst_n),
      .gate_i     (gate_i),
      .fast_clr_i (fast_clr_i),
      .hit_i      (hit_i),
      .clr_mask_i (clr_mask),
      .latch_q    (latch_q)
   );

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      assign rows[l]     = latch_q[l*NUM_COLS +: NUM_COLS];
      assign line_any[l] = |rows[l];
   end

   assign row_bits = rows[cur_line];

   first_set_finder #(.W(NUM_LINES), .IDX_W(LINE_W)) u_line_pick (
      .vec_i (line_any),
      .any_o (any_line),
      .idx_o (first_line)
   );

   first_set_finder #(.W(NUM_COLS), .IDX_W(COL_W)) u_col_pick (
      .vec_i (row_bits),
      .any_o (any_col),
      .idx_o (first_col)
   );

   assign walk_hit = (state == ST_WALK) && any_col;

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_clr_line
      for (genvar c = 0; c < NUM_COLS; c++) begin : g_clr_col
         assign clr_mask[l*NUM_COLS + c] = walk_hit && (cur_line == LINE_W'(l))
                                           && (first_col == COL_W'(c));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         cur_line     <= '0;
         addr_valid_o <= 1'b0;
         addr_o       <= '0;
         done_o       <= 1'b0;
      end else begin
         addr_valid_o <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (scan_start_i) begin
                  done_o <= 1'b0;
                  state  <= ST_SEEK;
               end
            end
            ST_SEEK: begin
               if (any_line) begin
                  cur_line <= first_line;
                  state    <= ST_WALK;
               end else begin
                  done_o <= 1'b1;
                  state  <= ST_IDLE;
               end
            end
            ST_WALK: begin
               if (any_col) begin
                  addr_valid_o <= 1'b1;
                  addr_o       <= {cur_line, first_col};
               end else begin
                  state <= ST_SEEK;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_COLS_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid_o && $past(addr_valid_o) |->
         (addr_o[ADDR_W-1:COL_W] == $past(addr_o[ADDR_W-1:COL_W]))
         && (addr_o[COL_W-1:0] > $past(addr_o[COL_W-1:0]))); // R6

   AST_ADDR_IN_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid_o |-> (int'(addr_o[COL_W-1:0]) < NUM_COLS)
                    && (int'(addr_o[ADDR_W-1:COL_W]) < NUM_LINES)); // R4

   AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && addr_valid_o)); // R9

   AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !scan_start_i |=> done_o); // R9

   AST_WALK_LINE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WALK) |-> (int'(cur_line) < NUM_LINES)); // R5
endmodule

// File: tb/pixel_sparse_scan_tb.sv
module pixel_sparse_scan_tb_top;
   localparam int NL = 24;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic gate = 1'b0;
   logic fclr = 1'b0;
   logic start = 1'b0;
   logic [575:0] hit = '0;
   logic v24, v16, d24, d16;
   logic [9:0] a24, a16;

   always #2 clk = ~clk;

   pixel_sparse_scan dut_i (
      .clk(clk), .rst_n(rst_n), .gate_i(gate), .fast_clr_i(fclr),
      .hit_i(hit), .scan_start_i(start),
      .addr_valid_o(v24), .addr_o(a24), .done_o(d24));

   pixel_sparse_scan #(.NUM_COLS(16)) dut16_i (
      .clk(clk), .rst_n(rst_n), .gate_i(gate), .fast_clr_i(fclr),
      .hit_i(hit[383:0]), .scan_start_i(start),
      .addr_valid_o(v16), .addr_o(a16), .done_o(d16));

   int checks = 0;
   int failures = 0;
   int cyc_total = 0;
   logic [575:0] model = '0;
   logic [9:0] got24 [0:699];
   logic [9:0] got16 [0:699];
   int n24, n16, cy24, cy16;
   logic [31:0] seed = 32'h1234_5678;

   always @(posedge clk) begin
      cyc_total <= cyc_total + 1;
      if (cyc_total == 190000) begin
         failures = failures + 1;
         $display("FAIL watchdog expired act=%0d exp=<190000", cyc_total);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_cycles(input logic [575:0] p, input int nc);
      int n = 2;
      for (int l = 0; l < NL; l++) begin
         int h = 0;
         for (int c = 0; c < nc; c++) if (p[l*nc + c]) h++;
         if (h > 0) n += h + 2;
      end
      return n;
   endfunction

   function automatic int exp_count(input logic [575:0] p, input int nc);
      int n = 0;
      for (int i = 0; i < NL*nc; i++) if (p[i]) n++;
      return n;
   endfunction

   // first position where the stream departs from line-major order, or -1
   function automatic int list_mismatch24(input logic [575:0] p);
      int k = 0;
      for (int l = 0; l < NL; l++)
         for (int c = 0; c < 24; c++)
            if (p[l*24 + c]) begin
               if (got24[k] != {l[4:0], c[4:0]}) return k;
               k++;
            end
      return -1;
   endfunction

   function automatic int list_mismatch16(input logic [575:0] p);
      int k = 0;
      for (int l = 0; l < NL; l++)
         for (int c = 0; c < 16; c++)
            if (p[l*16 + c]) begin
               if (got16[k] != {l[4:0], c[4:0]}) return k;
               k++;
            end
      return -1;
   endfunction

   task automatic load(input logic [575:0] p);
      hit = p; gate = 1'b1;
      @(negedge clk);
      hit = '0; gate = 1'b0;
      model = model | p;
   endtask

   task automatic do_scan(input string tag);
      int cnt = 0;
      bit s24 = 0, s16 = 0;
      n24 = 0; n16 = 0; cy24 = -1; cy16 = -1;
      start = 1'b1;
      while (!(s24 && s16) && cnt < 2000) begin
         @(negedge clk);
         cnt++;
         if (cnt == 1) begin
            start = 1'b0;
            chk({tag, " R9 done drops at start"}, int'(d24), 0);
         end
         if (v24 && n24 < 700) begin got24[n24] = a24; n24++; end
         if (v16 && n16 < 700) begin got16[n16] = a16; n16++; end
         if (d24 && !s24) begin s24 = 1; cy24 = cnt; end
         if (d16 && !s16) begin s16 = 1; cy16 = cnt; end
      end
      chk({tag, " R6 count 24col"}, n24, exp_count(model, 24));
      chk({tag, " R5 R4 order 24col"}, list_mismatch24(model), -1);
      chk({tag, " R8 cycles 24col"}, cy24, exp_cycles(model, 24));
      chk({tag, " R10 count 16col"}, n16, exp_count(model, 16));
      chk({tag, " R10 order 16col"}, list_mismatch16(model), -1);
      chk({tag, " R10 cycles 16col"}, cy16, exp_cycles(model, 16));
      chk({tag, " R9 done held"}, int'(d24 && d16), 1);
      model = '0;
   endtask

   function automatic logic [31:0] nxt(input logic [31:0] s);
      logic [31:0] t = s;
      t ^= t << 13; t ^= t >> 17; t ^= t << 5;
      return t;
   endfunction

   initial begin
      logic [575:0] p;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 valid after reset", int'(v24 || v16), 0);
      chk("R1 done after reset", int'(d24 || d16), 0);
      do_scan("R1 empty after reset");

      // R2 ungated hits ignored
      hit = '1; gate = 1'b0;
      @(negedge clk);
      hit = '0;
      do_scan("R2 gate low");

      // single pixel sweep
      for (int i = 0; i < 576; i++) begin
         p = '0; p[i] = 1'b1;
         load(p);
         do_scan("R4 single pixel");
      end

      // full array and rescan
      load('1);
      do_scan("R6 full map");
      do_scan("R7 rescan empty");

      // even lines only
      p = '0;
      for (int l = 0; l < NL; l += 2) p[l*24 +: 24] = 24'h5A5A5A;
      load(p);
      do_scan("R5 even lines 24col layout");

      // two gated captures merge
      p = '0; p[0] = 1'b1; load(p);
      p = '0; p[575] = 1'b1; p[300] = 1'b1; load(p);
      do_scan("R2 merged captures");

      // fast clear
      load('1);
      fclr = 1'b1;
      @(negedge clk);
      fclr = 1'b0;
      model = '0;
      do_scan("R3 fast clear");

      // fast clear together with gated capture
      hit = '1; gate = 1'b1; fclr = 1'b1;
      @(negedge clk);
      hit = '0; gate = 1'b0; fclr = 1'b0;
      do_scan("R3 clear beats capture");

      // pseudo-random maps of varying density
      for (int t = 0; t < 30; t++) begin
         for (int w = 0; w < 18; w++) begin
            logic [31:0] a, b;
            seed = nxt(seed); a = seed;
            seed = nxt(seed); b = seed;
            case (t % 3)
               0: p[w*32 +: 32] = a & b;
               1: p[w*32 +: 32] = a;
               default: p[w*32 +: 32] = a | b;
            endcase
         end
         load(p);
         do_scan("R5 R6 random map");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule